// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits next to a memory ECC checker and keeps a record of the first memory error the checker reports. The checker has two event inputs, one for corrected (single-bit) errors and one for uncorrectable (multi-bit) errors. Each event carries its failing address and its 8-bit syndrome. The block keeps the upper 19 address bits, the syndrome, and a flag that shows which kind of error was recorded. After that it ignores every later error until software clears the record.

All of this state sits in one 32-bit register, which software reaches through a simple write strobe and a read bus that is always valid. The register bits are:

| Bits | Access | Content |
|---|---|---|
| 31 | read/write | scrub disable |
| 30:12 | read-only | captured address bits [31:13], so one step is 8 KB |
| 11:4 | read-only | captured syndrome |
| 3 | read/write | bus-error enable |
| 2 | read/write | NMI enable |
| 1 | write-one-to-clear | multi-bit flag |
| 0 | write-one-to-clear | single-bit flag |

From the same state the block drives three outputs:
- an NMI request, a level, for a recorded correctable error;
- a bus-error request, a level, for a recorded uncorrectable error;
- a one-cycle scrub request for each corrected read while scrubbing is enabled.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every bit of `reg_rdata` is 0, and `nmi_req`, `berr_req` and `scrub_req` are low.
- R2: When `reg_wr` is high, bits 31, 3 and 2 take the written value. The value reads back from the next cycle on. Writes never change bits 30:4.
- R3: With both flags clear, a `ce_valid` event sets bit 0 at the next edge. The same edge loads `ce_addr[31:13]` into bits 30:12 and `ce_syn` into bits 11:4.
- R4: With both flags clear, a `ue_valid` event sets bit 1 at the next edge. The same edge loads `ue_addr[31:13]` into bits 30:12 and `ue_syn` into bits 11:4.
- R5: While either flag is set, later events of either kind are ignored. The address, syndrome and flag bits keep their values, and the other flag stays 0.
- R6: If `ce_valid` and `ue_valid` are high in the same cycle while both flags are clear, the multi-bit event is recorded: bit 1 is set, bit 0 stays 0, and the `ue_*` address and syndrome are loaded.
- R7: A write with bits 1 and 0 both set to 1 clears both flags. A write in which either of those bits is 0 leaves both flags unchanged.
- R8: After a clear, the next event is recorded. An event that arrives in the same cycle as the clearing write is ignored.
- R9: `nmi_req` is high exactly when bit 0 and bit 2 are both 1.
- R10: `berr_req` is high exactly when bit 1 and bit 3 are both 1.
- R11: `scrub_req` is high for the one cycle after each cycle in which `ce_valid` is high and bit 31 held 0 before that cycle's edge. It is low otherwise. The flags do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_valid | input | 1 | Corrected single-bit error event |
| ce_addr | input | 32 | Address of the corrected error |
| ce_syn | input | 8 | Syndrome of the corrected error |
| ue_valid | input | 1 | Uncorrectable multi-bit error event |
| ue_addr | input | 32 | Address of the uncorrectable error |
| ue_syn | input | 8 | Syndrome of the uncorrectable error |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| nmi_req | output | 1 | NMI request level |
| berr_req | output | 1 | Bus-error request level |
| scrub_req | output | 1 | One-cycle scrub request |

## Verification
The assertions check the following on every cycle:
- the two flags are never set together;
- the record is frozen while a flag is set and no clear is written;
- a clearing write empties both flags;
- the multi-bit event wins when both flags are clear;
- the scrub pulse follows each corrected event when scrubbing is enabled;
- the request levels are consistent with the register bits.

Only the bench scenarios can show the following:
- the exact captured address slice and syndrome;
- that the read-only fields ignore writes;
- that a write with a single flag bit set is ignored;
- that an event in the cycle of a clearing write is lost;
- how long sequences of mixed events, writes and clears behave over time.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_SBE  = 2'd1,
    ERR_MBE  = 2'd2
  } err_kind_e;

  // low register field positions (software decodes these)
  localparam int unsigned POS_SBE  = 0;
  localparam int unsigned POS_MBE  = 1;
  localparam int unsigned POS_NMI  = 2;
  localparam int unsigned POS_BERR = 3;
  localparam int unsigned POS_SYN  = 4;

  // a clear command needs both flag bits written as one
  function automatic logic is_clear_cmd(input logic wr, input logic [1:0] flag_bits);
    return wr & flag_bits[1] & flag_bits[0];
  endfunction
endpackage

// File: rtl/ecc_evt_pick.sv
module ecc_evt_pick
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CAPT_W = 19,
  parameter int unsigned SYN_W  = 8
) (
  input  logic              ce_valid,
  input  logic [ADDR_W-1:0] ce_addr,
  input  logic [SYN_W-1:0]  ce_syn,
  input  logic              ue_valid,
  input  logic [ADDR_W-1:0] ue_addr,
  input  logic [SYN_W-1:0]  ue_syn,
  output err_kind_e         pick_kind,
  output logic [CAPT_W-1:0] pick_hi,
  output logic [SYN_W-1:0]  pick_syn
);
  // keep the top CAPT_W address bits
  function automatic logic [CAPT_W-1:0] upper_bits(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: CAPT_W];
  endfunction

  // multi-bit error has priority
  always_comb begin
    pick_kind = ERR_NONE;
    pick_hi   = '0;
    pick_syn  = '0;
    if (ue_valid) begin
      pick_kind = ERR_MBE;
      pick_hi   = upper_bits(ue_addr);
      pick_syn  = ue_syn;
    end else if (ce_valid) begin
      pick_kind = ERR_SBE;
      pick_hi   = upper_bits(ce_addr);
      pick_syn  = ce_syn;
    end
  end
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store
  import ecc_cap_pkg::*;
#(
  parameter int unsigned CAPT_W = 19,
  parameter int unsigned SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  err_kind_e         pick_kind,
  input  logic [CAPT_W-1:0] pick_hi,
  input  logic [SYN_W-1:0]  pick_syn,
  input  logic              clr_cmd,
  output logic              sbe_q,
  output logic              mbe_q,
  output logic [CAPT_W-1:0] hi_q,
  output logic [SYN_W-1:0]  syn_q,
  output logic              busy,
  output logic              cap_fire,
  output logic              clr_fire
);
  assign busy     = sbe_q | mbe_q;
  assign cap_fire = !busy && (pick_kind != ERR_NONE);
  assign clr_fire = busy && clr_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
      hi_q  <= '0;
      syn_q <= '0;
    end else if (clr_fire) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
    end else if (cap_fire) begin
      sbe_q <= (pick_kind == ERR_SBE);
      mbe_q <= (pick_kind == ERR_MBE);
      hi_q  <= pick_hi;
      syn_q <= pick_syn;
    end
  end

  p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sbe_q && mbe_q));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr_cmd) |=> ($stable(hi_q) && $stable(syn_q) && $stable(sbe_q) && $stable(mbe_q)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (!sbe_q && !mbe_q));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (busy && hi_q == $past(pick_hi) && syn_q == $past(pick_syn)));
endmodule

// File: rtl/ecc_ctl_bits.sv
module ecc_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wd_scrub_dis,
  input  logic wd_berr_en,
  input  logic wd_nmi_en,
  input  logic ce_valid,
  output logic scrub_dis,
  output logic berr_en,
  output logic nmi_en,
  output logic scrub_req
);
  logic scrub_now;
  assign scrub_now = ce_valid && !scrub_dis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_dis <= 1'b0;
      berr_en   <= 1'b0;
      nmi_en    <= 1'b0;
      scrub_req <= 1'b0;
    end else begin
      scrub_req <= scrub_now;
      if (wr) begin
        scrub_dis <= wd_scrub_dis;
        berr_en   <= wd_berr_en;
        nmi_en    <= wd_nmi_en;
      end
    end
  end

  p_scrub_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_valid && !scrub_dis) |=> scrub_req);

  p_scrub_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_valid || scrub_dis) |=> !scrub_req);

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (scrub_dis == $past(wd_scrub_dis) && berr_en == $past(wd_berr_en) && nmi_en == $past(wd_nmi_en)));
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CAPT_W = 19,
  parameter int unsigned SYN_W  = 8,
  localparam int unsigned REG_W = CAPT_W + SYN_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_valid,
  input  logic [ADDR_W-1:0] ce_addr,
  input  logic [SYN_W-1:0]  ce_syn,
  input  logic              ue_valid,
  input  logic [ADDR_W-1:0] ue_addr,
  input  logic [SYN_W-1:0]  ue_syn,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              nmi_req,
  output logic              berr_req,
  output logic              scrub_req
);
  localparam int unsigned POS_SCRUB = REG_W - 1;

  // assemble the readable word
  function automatic logic [REG_W-1:0] pack_word(
    input logic sd, input logic [CAPT_W-1:0] hi, input logic [SYN_W-1:0] syn,
    input logic be, input logic ne, input logic mf, input logic sf);
    return {sd, hi, syn, be, ne, mf, sf};
  endfunction

  err_kind_e         pick_kind;
  logic [CAPT_W-1:0] pick_hi;
  logic [SYN_W-1:0]  pick_syn;
  logic              sbe_q, mbe_q, busy, cap_fire, clr_fire, clr_cmd;
  logic [CAPT_W-1:0] hi_q;
  logic [SYN_W-1:0]  syn_q;
  logic              scrub_dis, berr_en, nmi_en;

  assign clr_cmd = is_clear_cmd(reg_wr, reg_wdata[POS_MBE:POS_SBE]);

  ecc_evt_pick #(.ADDR_W(ADDR_W), .CAPT_W(CAPT_W), .SYN_W(SYN_W)) u_pick (
    .ce_valid(ce_valid), .ce_addr(ce_addr), .ce_syn(ce_syn),
    .ue_valid(ue_valid), .ue_addr(ue_addr), .ue_syn(ue_syn),
    .pick_kind(pick_kind), .pick_hi(pick_hi), .pick_syn(pick_syn)
  );

  ecc_cap_store #(.CAPT_W(CAPT_W), .SYN_W(SYN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .pick_kind(pick_kind), .pick_hi(pick_hi), .pick_syn(pick_syn),
    .clr_cmd(clr_cmd),
    .sbe_q(sbe_q), .mbe_q(mbe_q), .hi_q(hi_q), .syn_q(syn_q),
    .busy(busy), .cap_fire(cap_fire), .clr_fire(clr_fire)
  );

  ecc_ctl_bits u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr),
    .wd_scrub_dis(reg_wdata[POS_SCRUB]),
    .wd_berr_en(reg_wdata[POS_BERR]),
    .wd_nmi_en(reg_wdata[POS_NMI]),
    .ce_valid(ce_valid),
    .scrub_dis(scrub_dis), .berr_en(berr_en), .nmi_en(nmi_en),
    .scrub_req(scrub_req)
  );

  assign reg_rdata = pack_word(scrub_dis, hi_q, syn_q, berr_en, nmi_en, mbe_q, sbe_q);
  assign nmi_req   = sbe_q & nmi_en;
  assign berr_req  = mbe_q & berr_en;

  p_mbe_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ue_valid) |=> (reg_rdata[POS_MBE] && !reg_rdata[POS_SBE]));

  p_ce_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ce_valid && !ue_valid) |=> reg_rdata[POS_SBE]);

  p_nmi_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (reg_rdata[POS_SBE] && reg_rdata[POS_NMI]));

  p_berr_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    berr_req == (reg_rdata[POS_MBE] && reg_rdata[POS_BERR]));

  p_no_clear_while_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && (ce_valid || ue_valid)) |=> !busy);
endmodule

// File: tb/sim_ecc_err_capture.sv
`timescale 1ns/1ps
module sim_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_valid = 1'b0, ue_valid = 1'b0, reg_wr = 1'b0;
  logic [31:0] ce_addr = '0, ue_addr = '0, reg_wdata = '0;
  logic [7:0]  ce_syn = '0, ue_syn = '0;
  logic [31:0] reg_rdata;
  logic        nmi_req, berr_req, scrub_req;

  always #4 clk = ~clk;

  ecc_err_capture u0 (
    .clk(clk), .rst_n(rst_n),
    .ce_valid(ce_valid), .ce_addr(ce_addr), .ce_syn(ce_syn),
    .ue_valid(ue_valid), .ue_addr(ue_addr), .ue_syn(ue_syn),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nmi_req(nmi_req), .berr_req(berr_req), .scrub_req(scrub_req)
  );

  typedef struct {
    logic [31:0] rd;
    logic        nmi, berr, scrub;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  // reference model state
  logic        m_sd = 0, m_be = 0, m_ne = 0, m_mf = 0, m_sf = 0;
  logic [18:0] m_hi = '0;
  logic [7:0]  m_syn = '0;

  task automatic step(input logic cv, input logic [31:0] ca, input logic [7:0] cs,
                      input logic uv, input logic [31:0] ua, input logic [7:0] us,
                      input logic w, input logic [31:0] wd, input string tag);
    exp_t e;
    logic sc;
    @(negedge clk);
    ce_valid = cv; ce_addr = ca; ce_syn = cs;
    ue_valid = uv; ue_addr = ua; ue_syn = us;
    reg_wr = w; reg_wdata = wd;
    @(posedge clk);
    #1;
    sc = cv && !m_sd;
    if (m_sf || m_mf) begin
      if (w && wd[1] && wd[0]) begin m_sf = 0; m_mf = 0; end
    end else if (uv) begin
      m_mf = 1; m_hi = ua[31:13]; m_syn = us;
    end else if (cv) begin
      m_sf = 1; m_hi = ca[31:13]; m_syn = cs;
    end
    if (w) begin m_sd = wd[31]; m_be = wd[3]; m_ne = wd[2]; end
    e.rd    = {m_sd, m_hi, m_syn, m_be, m_ne, m_mf, m_sf};
    e.nmi   = m_sf & m_ne;
    e.berr  = m_mf & m_be;
    e.scrub = sc;
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: pops one expectation per cycle and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (reg_rdata !== e.rd || nmi_req !== e.nmi || berr_req !== e.berr || scrub_req !== e.scrub) begin
        n_fail++;
        $display("FAIL %s: rdata=%h nmi=%b berr=%b scrub=%b expected rdata=%h nmi=%b berr=%b scrub=%b",
                 e.tag, reg_rdata, nmi_req, berr_req, scrub_req, e.rd, e.nmi, e.berr, e.scrub);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");

    // R2: writable control bits, read-only fields ignore writes
    step(0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R2 write all ones");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, "R2 write zeros");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0004, "R2 nmi enable");

    // R3 / R9 / R11: single-bit capture with NMI and scrub pulse
    step(1, 32'hDEAD_BEEF, 8'h5A, 0, 0, 0, 0, 0, "R3 R9 R11 sbe capture");
    idle("R11 scrub pulse ends");
    // R5: later errors ignored
    step(0, 0, 0, 1, 32'h1234_5678, 8'hC3, 0, 0, "R5 later mbe ignored");
    step(1, 32'h0000_2000, 8'h11, 0, 0, 0, 0, 0, "R5 later sbe ignored");
    // R7: single-bit clear writes have no effect
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0005, "R7 write bit0 only");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0006, "R7 write bit1 only");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0007, "R7 clear both");

    // R4 / R10: multi-bit capture with bus error
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0008, "R10 berr enable");
    step(0, 0, 0, 1, 32'hFFFF_E000, 8'hA5, 0, 0, "R4 R10 mbe capture");
    // R8: event in clearing cycle is lost, next is captured
    step(1, 32'h4000_0000, 8'h01, 0, 0, 0, 1, 32'h0000_000B, "R8 event during clear");
    idle("R8 still empty");
    step(1, 32'h8000_6000, 8'h3C, 0, 0, 0, 0, 0, "R8 next event captured");
    step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0003, "R7 clear again");

    // R6: simultaneous events
    step(1, 32'h1111_1111, 8'h22, 1, 32'h7777_7777, 8'h99, 0, 0, "R6 mbe wins");
    step(0, 0, 0, 0, 0, 0, 1, 32'h8000_0003, "R7 clear and scrub disable");
    // R11: scrub disabled
    step(1, 32'h0ABC_D000, 8'h44, 0, 0, 0, 0, 0, "R11 no scrub when disabled");
    step(1, 32'h0ABC_D000, 8'h44, 0, 0, 0, 1, 32'h0000_0003, "R11 clear, scrub still off");
    step(1, 32'h0, 8'h0, 0, 0, 0, 0, 0, "R11 scrub after enable");

    // mixed traffic against the model
    seed = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      logic cv, uv, w;
      logic [31:0] a1, a2, wd;
      seed = seed * 32'd1664525 + 32'd1013904223; cv = seed[28];
      a1 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; uv = seed[29] & seed[30];
      a2 = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; w = seed[27] & seed[26];
      wd = {seed[31], 27'h0, seed[3:0]};
      step(cv, a1, a1[7:0], uv, a2, a2[15:8], w, wd, "R5 R6 R7 R8 R11 mixed traffic");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule